// File: doc/BRIEF.md
# Write-Protected Wait-State Controller

This block keeps the wait-state settings for three memory regions in a small register bank, and it stretches each memory access by the number of clock cycles set for the region the access targets. The regions are a slow peripheral region and two internal RAM regions. A fourth region code stands for memory that never needs waits.

The settings registers are guarded by a key register. A write to a settings register is applied only while the key register holds 0x96. While the key holds any other value, such a write is dropped without notice. The key register itself can always be written. All registers can always be read. Software unlocks the bank, changes the settings, and then locks it again.

A requester drives `acc_req` together with a region code. The requester holds both until `acc_ready` goes high. A relocation input shows that the second RAM region has been mapped over the area of the first RAM region. While it is set, accesses tagged for the first region use the wait bit of the second region.

Top module: `wait_ctrl_top`

## Requirements
- R1: After reset, the key register reads 0x00, the slow-region wait field reads 7, and both RAM wait bits read 1. The bank therefore starts locked.
- R2: Register addresses are fixed. Address 0 is the 8-bit key. Address 1 holds the slow-region wait field in bits [2:0]. Address 2 holds the RAM-A wait bit in bit 0 and the RAM-B wait bit in bit 1. Unused bits and address 3 read 0, and writes to address 3 change nothing.
- R3: A write to address 1 or 2 changes the register only if the key register holds 0x96 at the clock edge of the write. Otherwise the write is dropped.
- R4: The key register accepts every write at any time, whether the bank is locked or unlocked.
- R5: A slow-region field of 0 still reads back as 0, but slow-region accesses then take 1 wait cycle. Slow-region accesses never take zero waits.
- R6: The cycle in which an idle controller sees `acc_req` high is cycle 0. For a wait count N, `acc_ready` is low in cycles 0 to N-1 and high for exactly one cycle, in cycle N. With N = 0, `acc_ready` is high in cycle 0.
- R7: Region codes select the wait count. Code 0 is the slow region and uses its field, subject to R5. Code 1 is RAM-A and uses its bit. Code 2 is RAM-B and uses its bit. Code 3 is direct memory with 0 waits.
- R8: While `remap` is 1, code-1 accesses take the RAM-B bit as their wait count, and the RAM-A bit has no effect on them.
- R9: The wait count is captured in cycle 0. A settings change made while an access is in progress affects only accesses that start later.
- R10: While an access is in progress, `acc_req` is not sampled. Each access produces exactly one ready cycle, and a request still high in the cycle after ready starts a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; wait counts are in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| acc_req | input | 1 | Access request, held until ready |
| acc_region | input | 2 | Target region code of the access |
| remap | input | 1 | RAM-B is mapped over the RAM-A area |
| acc_ready | output | 1 | Access may complete this cycle |

## Verification
Accesses are run for every region code at several wait counts, including 0, 1, 3, 5 and 7. This distinguishes an off-by-one in the ready timing from a wrong choice of wait source. Settings writes are issued while the bank is locked, after it has been unlocked, and after it has been locked again. This separates key gating from the key register's own write path. The relocation input is toggled with opposite values in the two RAM bits, so the bench can see which bit was used. One settings write lands in the middle of an access, to show the count was captured when the access started.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 2;
  localparam logic [REG_W-1:0] UNLOCK_KEY = 8'h96;
  localparam logic [REG_W-1:0] KEY_RESET  = 8'h00;

  localparam logic [ADDR_W-1:0] A_KEY  = 2'd0;
  localparam logic [ADDR_W-1:0] A_SLOW = 2'd1;
  localparam logic [ADDR_W-1:0] A_RAM  = 2'd2;

  typedef enum logic [1:0] {
    RGN_SLOW   = 2'd0,
    RGN_RAM_A  = 2'd1,
    RGN_RAM_B  = 2'd2,
    RGN_DIRECT = 2'd3
  } region_e;

  // Slow region must never run with zero waits: a field of 0 means one wait.
  function automatic logic [2:0] slow_waits(input logic [2:0] field);
    return (field == 3'd0) ? 3'd1 : field;
  endfunction

  // Code 1 follows the RAM-B bit while RAM-B is relocated over its area.
  function automatic logic ram_a_bit(input logic remap_i, input logic bit_a,
                                     input logic bit_b);
    return remap_i ? bit_b : bit_a;
  endfunction
endpackage

// File: rtl/wsc_regbank.sv
module wsc_regbank
  import wsc_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter logic [CNT_W-1:0] SLOW_RESET = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [CNT_W-1:0]  slow_field,
  output logic [1:0]        ram_bits,
  output logic              unlocked,
  output logic              prot_we
);
  localparam int PAD_SLOW = REG_W - CNT_W;
  localparam int PAD_RAM  = REG_W - 2;

  logic [REG_W-1:0] key_q;

  assign unlocked = (key_q == UNLOCK_KEY);
  assign prot_we  = we && ((addr == A_SLOW) || (addr == A_RAM));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q      <= KEY_RESET;
      slow_field <= SLOW_RESET;
      ram_bits   <= 2'b11;
    end else begin
      if (we && addr == A_KEY) key_q <= wdata;
      if (prot_we && unlocked) begin
        if (addr == A_SLOW) slow_field <= wdata[CNT_W-1:0];
        else                ram_bits   <= wdata[1:0];
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_KEY:   rdata = key_q;
      A_SLOW:  rdata = {{PAD_SLOW{1'b0}}, slow_field};
      A_RAM:   rdata = {{PAD_RAM{1'b0}}, ram_bits};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wsc_wait_sel.sv
module wsc_wait_sel
  import wsc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic [1:0]       region,
  input  logic             remap,
  input  logic [CNT_W-1:0] slow_field,
  input  logic [1:0]       ram_bits,
  output logic [CNT_W-1:0] need
);
  always_comb begin
    unique case (region_e'(region))
      RGN_SLOW:  need = CNT_W'(slow_waits(3'(slow_field)));
      RGN_RAM_A: need = CNT_W'(ram_a_bit(remap, ram_bits[0], ram_bits[1]));
      RGN_RAM_B: need = CNT_W'(ram_bits[1]);
      default:   need = '0;
    endcase
  end
endmodule

// File: rtl/wsc_wait_gen.sv
module wsc_wait_gen #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] need,
  output logic             start,
  output logic             busy,
  output logic             ready
);
  logic [CNT_W-1:0] left_q;

  assign start = req && !busy;
  assign ready = busy ? (left_q == '0) : (start && need == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (start && need != '0) begin
      busy   <= 1'b1;
      left_q <= need - 1'b1;
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/wait_ctrl_top.sv
module wait_ctrl_top
  import wsc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              acc_req,
  input  logic [1:0]        acc_region,
  input  logic              remap,
  output logic              acc_ready
);
  logic [CNT_W-1:0] slow_field;
  logic [1:0]       ram_bits;
  logic             unlocked;
  logic             prot_we;
  logic [CNT_W-1:0] need;
  logic             start;
  logic             busy;

  wsc_regbank #(.CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .slow_field(slow_field),
    .ram_bits(ram_bits), .unlocked(unlocked), .prot_we(prot_we)
  );

  wsc_wait_sel #(.CNT_W(CNT_W)) u_sel (
    .region(acc_region), .remap(remap), .slow_field(slow_field),
    .ram_bits(ram_bits), .need(need)
  );

  wsc_wait_gen #(.CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .req(acc_req), .need(need),
    .start(start), .busy(busy), .ready(acc_ready)
  );
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             unlocked,
  input logic             prot_we,
  input logic [CNT_W-1:0] slow_field,
  input logic [1:0]       ram_bits,
  input logic [1:0]       acc_region,
  input logic             remap,
  input logic [CNT_W-1:0] need,
  input logic             start,
  input logic             busy,
  input logic             acc_ready
);
  // R3
  locked_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_we && !unlocked) |=> ($stable(slow_field) && $stable(ram_bits)));

  // R5
  slow_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && acc_region == 2'd0) |-> (need != '0));

  // R6
  zero_wait_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && need == '0) |-> acc_ready);

  // R6
  ready_ends_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_ready) |=> !busy);

  // R8
  remap_uses_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && remap && acc_region == 2'd1) |-> (need == CNT_W'(ram_bits[1])));

  // R9
  wait_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && need > CNT_W'(1)) |=> (busy && !acc_ready));
endmodule

bind wait_ctrl_top wsc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .prot_we(prot_we),
  .slow_field(slow_field), .ram_bits(ram_bits), .acc_region(acc_region),
  .remap(remap), .need(need), .start(start), .busy(busy),
  .acc_ready(acc_ready)
);

// File: tb/wait_ctrl_top_test.sv
module wait_ctrl_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       acc_req = 1'b0;
  logic [1:0] acc_region = 2'd0;
  logic       remap = 1'b0;
  logic       acc_ready;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string phase = "R1";

  // Reference state
  int m_key, m_slow, m_ra, m_rb, m_left;
  bit m_busy;

  always #10 clk = ~clk;

  wait_ctrl_top uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_req(acc_req),
    .acc_region(acc_region), .remap(remap), .acc_ready(acc_ready)
  );

  task automatic chk(input string tag, input string what, input int act,
                     input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int waits_for(input int rgn);
    case (rgn)
      0: return (m_slow == 0) ? 1 : m_slow;
      1: return remap ? m_rb : m_ra;
      2: return m_rb;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_rdata();
    case (reg_addr)
      2'd0: return m_key;
      2'd1: return m_slow;
      2'd2: return m_rb * 2 + m_ra;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_ready();
    if (m_busy) return (m_left == 0) ? 1 : 0;
    return (acc_req && waits_for(acc_region) == 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_key = 0; m_slow = 7; m_ra = 1; m_rb = 1; m_busy = 0; m_left = 0;
    end else begin
      int n;
      bit open;
      open = (m_key == 8'h96);
      if (!m_busy && acc_req) begin
        n = waits_for(acc_region);
        if (n > 0) begin m_busy = 1; m_left = n - 1; end
      end else if (m_busy) begin
        if (m_left == 0) m_busy = 0; else m_left--;
      end
      if (reg_we) begin
        if (reg_addr == 2'd0) m_key = reg_wdata;
        else if (reg_addr == 2'd1 && open) m_slow = reg_wdata & 7;
        else if (reg_addr == 2'd2 && open) begin
          m_ra = reg_wdata[0]; m_rb = reg_wdata[1];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, "ready vs model", acc_ready, exp_ready());
      chk(phase, "rdata vs model", reg_rdata, exp_rdata());
    end
  end

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input int a, input int exp);
    reg_addr = 2'(a);
    @(negedge clk);
    chk(tag, "read", reg_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic access(input string tag, input int rgn, input int exp);
    int k;
    k = 0;
    acc_req = 1'b1; acc_region = 2'(rgn);
    forever begin
      @(negedge clk);
      if (acc_ready || k > 20) break;
      k++;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    acc_req = 1'b0;
    chk(tag, "wait cycles", k, exp);
    @(negedge clk);
    chk(tag, "single ready", acc_ready, 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    phase = "R1";
    rd("R1", 0, 8'h00); rd("R1", 1, 7); rd("R1", 2, 3);
    // R3 locked writes dropped
    phase = "R3";
    wr(1, 2); wr(2, 0);
    rd("R3", 1, 7); rd("R3", 2, 3);
    access("R3", 0, 7);
    // R4 key always writable
    phase = "R4";
    wr(0, 8'h55); rd("R4", 0, 8'h55);
    wr(0, 8'h96); rd("R4", 0, 8'h96);
    // R2 map and field widths
    phase = "R2";
    wr(1, 8'hFF); rd("R2", 1, 7);
    wr(2, 8'hFE); rd("R2", 2, 2);
    wr(3, 8'hAA); rd("R2", 3, 0);
    rd("R2", 0, 8'h96);
    // R7 per-region counts
    phase = "R7";
    wr(1, 3); wr(2, 1);
    access("R7", 0, 3); access("R7", 1, 1);
    access("R7", 2, 0); access("R7", 3, 0);
    // R5 zero field clamped
    phase = "R5";
    wr(1, 0); rd("R5", 1, 0);
    access("R5", 0, 1);
    // R8 relocation
    phase = "R8";
    remap = 1'b1;
    wr(2, 2); access("R8", 1, 1);
    wr(2, 1); access("R8", 1, 0);
    remap = 1'b0;
    access("R8", 1, 1);
    // R9 capture at start
    phase = "R9";
    wr(1, 5);
    fork
      access("R9", 0, 5);
      begin repeat (2) @(posedge clk); #1; wr(1, 2); end
    join
    access("R9", 0, 2);
    // R10 back-to-back requests held high
    phase = "R10";
    acc_req = 1'b1; acc_region = 2'd0;
    repeat (6) @(posedge clk); #1;
    acc_req = 1'b0;
    repeat (3) @(posedge clk); #1;
    access("R10", 0, 2);
    // R3 relock
    phase = "R3";
    wr(0, 8'h00); wr(1, 6);
    rd("R3", 1, 2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule